// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block drives an I2C bus as a master that only sends data. The host requests a start condition and then writes bytes one at a time into a holding register. The block moves each byte into a shift register, puts it on SDA most significant bit first, and reads the acknowledge bit during the ninth SCL pulse. The first byte after a start is the 7-bit target address followed by a direction bit (0 = write to the target, 1 = read from it). The block passes that byte through unchanged, like any other byte.

The holding register and the shift register form a double buffer, so the host can supply the next byte while the current one is on the wire. If a byte boundary arrives and no new byte is ready, the engine holds SCL low. It keeps SCL low until the host writes a byte or asks for a stop. A stop releases SDA while SCL is high, raises a stop-detected flag and returns the engine to idle.

Both bus lines are open-drain. Each has an active-high pull-low enable, and SDA also has an input. One SCL period is four quarters, and one quarter is `quarterDiv + 1` system clocks. SDA only changes while SCL is low, exactly one quarter after SCL falls. The only exceptions are the start and stop conditions.

Top module: `i2cTxMaster`

## Requirements
- R1: After reset: bufEmpty=1; txEnd, nackFlag, ackBit, busBusy and stopDet are all 0; sclOe=0 and sdaOe=0, so both lines are released.
- R2: A startReq pulse while busBusy=0 sets busBusy on the next clock and produces a start condition: SDA falls while SCL is high. A startReq while busBusy=1 has no effect on the bus, and no second start appears.
- R3: Each byte goes out MSB first, one bit per SCL pulse. Within a byte, consecutive SCL rising edges are 4*(quarterDiv+1) clocks apart. SDA never changes while SCL is high, except for a start or a stop.
- R4: Asserting dataWr loads dataIn into the holding register and clears bufEmpty on that clock. Moving the byte into the shift register at the start of its first bit sets bufEmpty again. If a write and a transfer happen on the same clock, the write wins.
- R5: txEnd is set on the rising edge of a byte's ninth SCL pulse only if bufEmpty is 1 at that moment. If the next byte is already waiting, txEnd stays 0.
- R6: The level of SDA sampled during the ninth SCL pulse is stored in ackBit (0 = acknowledged, 1 = not acknowledged).
- R7: nackFlag is set by a sampled 1 only when nackDetEn=1. With nackDetEn=0 a not-acknowledged byte leaves nackFlag at 0.
- R8: When a byte (or the start) finishes and no byte is waiting, SCL is held low with no further pulses until dataWr or stopReq.
- R9: A stopReq while busBusy=1 produces a stop condition (SDA rises while SCL is high) at the next byte boundary, or immediately while SCL is held low. When the stop completes, stopDet=1, busBusy=0, and both lines are released.
- R10: clrFlags is write-one-to-clear: bit 0 clears txEnd, bit 1 clears nackFlag, bit 2 clears stopDet. Flags whose clear bit is 0 keep their value.
- R11: At a byte boundary a pending stop takes priority over a byte waiting in the holding register. That byte is never sent, and bufEmpty reads 1 once the stop completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| quarterDiv | input | DIV_W | One SCL quarter lasts quarterDiv+1 clocks |
| startReq | input | 1 | Request a start condition (accepted only while the bus is free) |
| stopReq | input | 1 | Request a stop condition |
| dataWr | input | 1 | Write strobe for the holding register |
| dataIn | input | 8 | Byte to transmit |
| nackDetEn | input | 1 | Enable the no-acknowledge flag |
| clrFlags | input | 3 | Write-one-to-clear: {stopDet, nackFlag, txEnd} |
| bufEmpty | output | 1 | Holding register empty |
| txEnd | output | 1 | Byte finished with no follow-on data |
| ackBit | output | 1 | Last acknowledge sample (1 = not acknowledged) |
| nackFlag | output | 1 | Not-acknowledged seen while detection was enabled |
| busBusy | output | 1 | Engine owns the bus (start issued, stop not finished) |
| stopDet | output | 1 | Stop condition completed |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |
| sdaIn | input | 1 | Sampled SDA line level |

## Verification
The bench targets these cases:
- A stall longer than a byte, so the engine must park with SCL low. A design that kept clocking would send garbage bits, or ones the bench reads as a phantom byte.
- A second byte written during the first, so the ninth-pulse test of bufEmpty matters. A design that checked it late would raise txEnd spuriously, or send an extra byte.
- A stop requested while a byte still waits in the holding register. A design that got the priority wrong would send that byte, or carry it into the next transfer.
- Random bytes and SCL dividers, checked by a bus monitor that decodes starts, stops and bits. This catches bit-order, period and SDA-while-SCL-high mistakes.
- Not-acknowledged bytes, with the enable both on and off, to separate ackBit from nackFlag.

// File: rtl/i2cTxPkg.sv
package i2cTxPkg;
  localparam int DATA_W    = 8;
  localparam int BIT_SLOTS = DATA_W + 1;
  localparam int SLOT_W    = $clog2(BIT_SLOTS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_HOLD,
    ST_STOP
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // holding register -> shift register
    logic shift;      // advance to next bit
    logic ninthRise;  // SCL rising on the acknowledge pulse
    logic ackSample;  // sample SDA for acknowledge
    logic discard;    // stop finished: drop unsent data
  } dpCtrl_t;
endpackage

// File: rtl/i2cTxData.sv
module i2cTxData
  import i2cTxPkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtrl_t       ctl,
  input  logic          dataWr,
  input  logic [DW-1:0] dataIn,
  input  logic          nackDetEn,
  input  logic [1:0]    clrFlags,
  input  logic          sdaIn,
  output logic          shMsb,
  output logic          bufEmpty,
  output logic          txEnd,
  output logic          ackBit,
  output logic          nackFlag
);
  logic [DW-1:0] holdReg;
  logic [DW-1:0] shiftReg;

  assign shMsb = shiftReg[DW-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '0;
      bufEmpty <= 1'b1;
    end else begin
      if (ctl.load) begin
        shiftReg <= holdReg;
        bufEmpty <= 1'b1;
      end else if (ctl.shift) begin
        shiftReg <= {shiftReg[DW-2:0], 1'b0};
      end
      if (ctl.discard) bufEmpty <= 1'b1;
      if (dataWr) begin
        holdReg  <= dataIn;
        bufEmpty <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEnd    <= 1'b0;
      ackBit   <= 1'b0;
      nackFlag <= 1'b0;
    end else begin
      if (clrFlags[0]) txEnd <= 1'b0;
      if (clrFlags[1]) nackFlag <= 1'b0;
      if (ctl.ninthRise && bufEmpty) txEnd <= 1'b1;
      if (ctl.ackSample) begin
        ackBit <= sdaIn;
        if (nackDetEn && sdaIn) nackFlag <= 1'b1;
      end
    end
  end

  // R4
  wr_clears_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> !bufEmpty);

  // R5
  tend_needs_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnd) |-> $past(bufEmpty));

  // R7
  nack_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nackFlag) |-> ($past(nackDetEn) && ackBit));
endmodule

// File: rtl/i2cTxCtrl.sv
module i2cTxCtrl
  import i2cTxPkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] quarterDiv,
  input  logic             startReq,
  input  logic             stopReq,
  input  logic [0:0]       clrStop,
  input  logic             bufEmpty,
  input  logic             shMsb,
  output dpCtrl_t          ctl,
  output logic             busBusy,
  output logic             stopDet,
  output logic             sclLow,
  output logic             sdaLow
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(BIT_SLOTS - 1);

  txState_e          st;
  logic [DIV_W-1:0]  divCnt;
  logic [1:0]        q;
  logic [SLOT_W-1:0] bitIdx;
  logic              stopPend;
  logic              tick;
  logic              stopNow;
  logic              boundaryEnd;
  logic              loadNow;

  assign tick        = (divCnt == quarterDiv);
  assign stopNow     = stopPend | (stopReq & busBusy);
  assign boundaryEnd = tick && (q == 2'd3) &&
                       ((st == ST_START) || ((st == ST_BIT) && (bitIdx == LAST_SLOT)));
  assign loadNow     = ((st == ST_HOLD) || boundaryEnd) && !stopNow && !bufEmpty;

  assign ctl.load      = loadNow;
  assign ctl.shift     = (st == ST_BIT) && tick && (q == 2'd3) && (bitIdx != LAST_SLOT);
  assign ctl.ninthRise = (st == ST_BIT) && (bitIdx == LAST_SLOT) && tick && (q == 2'd1);
  assign ctl.ackSample = (st == ST_BIT) && (bitIdx == LAST_SLOT) && tick && (q == 2'd2);
  assign ctl.discard   = (st == ST_STOP) && tick && (q == 2'd3);

  // quarters 0,1 low and 2,3 high in bit and stop slots; start pulls low in its last quarter
  assign sclLow = (st == ST_HOLD) ||
                  ((st == ST_START) && (q == 2'd3)) ||
                  (((st == ST_BIT) || (st == ST_STOP)) && (q < 2'd2));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      divCnt   <= '0;
      q        <= '0;
      bitIdx   <= '0;
      sdaLow   <= 1'b0;
      busBusy  <= 1'b0;
      stopPend <= 1'b0;
      stopDet  <= 1'b0;
    end else begin
      if (clrStop[0]) stopDet <= 1'b0;
      if (stopReq && busBusy) stopPend <= 1'b1;
      case (st)
        ST_IDLE: begin
          if (startReq) begin
            st       <= ST_START;
            busBusy  <= 1'b1;
            stopPend <= 1'b0;
            divCnt   <= '0;
            q        <= '0;
          end
        end
        ST_HOLD: begin
          divCnt <= '0;
          q      <= '0;
          if (stopNow) begin
            st <= ST_STOP;
          end else if (loadNow) begin
            st     <= ST_BIT;
            bitIdx <= '0;
          end
        end
        default: begin
          if (tick) begin
            divCnt <= '0;
            q      <= q + 2'd1;
            case (st)
              ST_START: if (q == 2'd0) sdaLow <= 1'b1;
              ST_BIT: begin
                if (q == 2'd0) sdaLow <= (bitIdx == LAST_SLOT) ? 1'b0 : ~shMsb;
                if ((q == 2'd3) && (bitIdx != LAST_SLOT)) bitIdx <= bitIdx + 1'b1;
              end
              ST_STOP: begin
                if (q == 2'd0) sdaLow <= 1'b1;
                if (q == 2'd2) sdaLow <= 1'b0;
                if (q == 2'd3) begin
                  st       <= ST_IDLE;
                  busBusy  <= 1'b0;
                  stopPend <= 1'b0;
                  stopDet  <= 1'b1;
                end
              end
              default: ;
            endcase
            if (boundaryEnd) begin
              if (stopNow) begin
                st <= ST_STOP;
              end else if (!bufEmpty) begin
                st     <= ST_BIT;
                bitIdx <= '0;
              end else begin
                st <= ST_HOLD;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R3
  sda_only_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sclLow && (sdaLow != $past(sdaLow))) |-> ((st == ST_START) || (st == ST_STOP)));

  // R8
  hold_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((st == ST_HOLD) && bufEmpty && !stopReq && !stopPend) |=> (st == ST_HOLD));

  // R2
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busBusy) |-> $past(startReq));

  // R9
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopDet) |-> (!busBusy && (st == ST_IDLE)));
endmodule

// File: rtl/i2cTxMaster.sv
module i2cTxMaster
  import i2cTxPkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] quarterDiv,
  input  logic             startReq,
  input  logic             stopReq,
  input  logic             dataWr,
  input  logic [7:0]       dataIn,
  input  logic             nackDetEn,
  input  logic [2:0]       clrFlags,
  output logic             bufEmpty,
  output logic             txEnd,
  output logic             ackBit,
  output logic             nackFlag,
  output logic             busBusy,
  output logic             stopDet,
  output logic             sclOe,
  output logic             sdaOe,
  input  logic             sdaIn
);
  dpCtrl_t ctl;
  logic    shMsb;
  logic    sclLow;
  logic    sdaLow;

  i2cTxCtrl #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .quarterDiv(quarterDiv),
    .startReq(startReq), .stopReq(stopReq), .clrStop(clrFlags[2:2]),
    .bufEmpty(bufEmpty), .shMsb(shMsb), .ctl(ctl),
    .busBusy(busBusy), .stopDet(stopDet), .sclLow(sclLow), .sdaLow(sdaLow)
  );

  i2cTxData #(.DW(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataWr(dataWr), .dataIn(dataIn),
    .nackDetEn(nackDetEn), .clrFlags(clrFlags[1:0]), .sdaIn(sdaIn),
    .shMsb(shMsb), .bufEmpty(bufEmpty), .txEnd(txEnd),
    .ackBit(ackBit), .nackFlag(nackFlag)
  );

  assign sclOe = sclLow;
  assign sdaOe = sdaLow;
endmodule

// File: tb/tb_i2cTxMaster.sv
module tb_i2cTxMaster;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] quarterDiv = 8'd1;
  logic       startReq = 1'b0, stopReq = 1'b0, dataWr = 1'b0, nackDetEn = 1'b0;
  logic [7:0] dataIn = 8'd0;
  logic [2:0] clrFlags = 3'd0;
  logic       bufEmpty, txEnd, ackBit, nackFlag, busBusy, stopDet, sclOe, sdaOe;
  logic       ackDrive = 1'b0;
  logic       sclLine, sdaLine;

  assign sclLine = ~sclOe;
  assign sdaLine = ~sdaOe & ~ackDrive;

  i2cTxMaster dut (
    .clk(clk), .rstN(rstN), .quarterDiv(quarterDiv), .startReq(startReq),
    .stopReq(stopReq), .dataWr(dataWr), .dataIn(dataIn), .nackDetEn(nackDetEn),
    .clrFlags(clrFlags), .bufEmpty(bufEmpty), .txEnd(txEnd), .ackBit(ackBit),
    .nackFlag(nackFlag), .busBusy(busBusy), .stopDet(stopDet),
    .sclOe(sclOe), .sdaOe(sdaOe), .sdaIn(sdaLine)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int expPeriod(input int qd);
    return 4 * (qd + 1);
  endfunction

  function automatic bit expNack(input int idx, input int nk);
    return idx == nk;
  endfunction

  // bus monitor acting as a target device
  int         bitCnt = 0, rxCount = 0, startCnt = 0, stopCnt = 0;
  int         nackIdx = 99, curQ = 1, lastRise = 0;
  logic [7:0] rxShift = 8'd0;
  logic [7:0] rxBuf [16];
  logic       prevScl = 1'b1, prevSda = 1'b1;

  always @(negedge clk) begin
    logic s, d;
    s = sclLine;
    d = sdaLine;
    if (!rstN) begin
      ackDrive = 1'b0;
      bitCnt = 0;
    end else begin
      if (s && prevScl) begin
        if (prevSda && !d) begin
          startCnt++;
          bitCnt = 0;
          rxCount = 0;
        end else if (!prevSda && d) begin
          stopCnt++;
        end
      end
      if (s && !prevScl) begin
        if (bitCnt >= 1 && bitCnt <= 8)
          chk((cyc - lastRise) == expPeriod(curQ), "R3 scl period", cyc - lastRise, expPeriod(curQ));
        lastRise = cyc;
        if (bitCnt < 8) begin
          rxShift = {rxShift[6:0], d};
          bitCnt++;
          if (bitCnt == 8) begin
            if (rxCount < 16) rxBuf[rxCount] = rxShift;
            rxCount++;
          end
        end else if (bitCnt == 8) begin
          bitCnt = 9;
        end
      end
      if (!s && prevScl) begin
        if (bitCnt == 8) ackDrive = !expNack(rxCount - 1, nackIdx);
        else if (bitCnt == 9) begin
          ackDrive = 1'b0;
          bitCnt = 0;
        end
      end
    end
    prevScl = s;
    prevSda = d;
  end

  always @(negedge clk) begin
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStart();
    startReq = 1'b1; @(negedge clk); startReq = 1'b0;
  endtask

  task automatic pulseStop();
    stopReq = 1'b1; @(negedge clk); stopReq = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] b);
    dataIn = b; dataWr = 1'b1; @(negedge clk); dataWr = 1'b0;
  endtask

  task automatic clear(input logic [2:0] m);
    clrFlags = m; @(negedge clk); clrFlags = 3'd0;
  endtask

  task automatic waitEmpty();
    int t = 0;
    while (!bufEmpty && t < 5000) begin @(negedge clk); t++; end
    chk(bufEmpty, "R4 empty after transfer", bufEmpty, 1);
  endtask

  task automatic waitTxEnd();
    int t = 0;
    while (!txEnd && t < 5000) begin @(negedge clk); t++; end
    chk(txEnd, "R5 txEnd at last byte", txEnd, 1);
  endtask

  task automatic waitIdle();
    int t = 0;
    while (busBusy && t < 5000) begin @(negedge clk); t++; end
    chk(!busBusy, "R9 busBusy cleared", busBusy, 0);
  endtask

  // one full transfer: n bytes, target refuses byte nk (nk >= n: all acknowledged)
  task automatic runTxn(input int n, input int nk, input bit en, input int stall,
                        input int qd, input bit extraStart);
    logic [7:0] exp [8];
    int lastByte, s0, p0;
    bit nacked;
    quarterDiv = 8'(qd); curQ = qd; nackIdx = nk; nackDetEn = en;
    exp[0] = {7'($urandom), 1'b0};
    for (int i = 1; i < 8; i++) exp[i] = 8'($urandom);
    nacked = (nk < n);
    lastByte = nacked ? nk : n - 1;
    s0 = startCnt; p0 = stopCnt;
    chk(!busBusy, "R2 bus free before start", busBusy, 0);
    pulseStart();
    chk(busBusy, "R2 busBusy after start", busBusy, 1);
    if (stall > 0) begin
      idle(stall + 6 * (qd + 1));
      chk(sclOe == 1'b1 && rxCount == 0 && bitCnt == 0, "R8 parked after start",
          int'(sclOe) + 2 * rxCount, 1);
    end
    for (int i = 0; i <= lastByte; i++) begin
      waitEmpty();
      if (stall > 0 && i == lastByte && i > 0) idle(stall);
      writeByte(exp[i]);
      chk(!bufEmpty, "R4 write clears empty", bufEmpty, 0);
      if (extraStart && i == 0) pulseStart();
      if (txEnd) clear(3'b001);
    end
    waitTxEnd();
    idle(2 * (qd + 1) + 2);
    chk(ackBit == nacked, "R6 ack sample", ackBit, nacked);
    chk(nackFlag == (nacked && en), "R7 nack flag", nackFlag, nacked && en);
    idle(8 * (qd + 1));
    chk(sclOe == 1'b1 && rxCount == lastByte + 1, "R8 parked after byte",
        rxCount, lastByte + 1);
    pulseStop();
    waitIdle();
    chk(stopDet, "R9 stopDet", stopDet, 1);
    chk(stopCnt == p0 + 1, "R9 stop on bus", stopCnt - p0, 1);
    chk(startCnt == s0 + 1, "R2 one start on bus", startCnt - s0, 1);
    chk(!sclOe && !sdaOe, "R9 lines released", int'(sclOe) + int'(sdaOe), 0);
    for (int i = 0; i <= lastByte; i++)
      chk(rxBuf[i] == exp[i], "R3 byte content", rxBuf[i], exp[i]);
    clear(3'b111);
    chk(!txEnd && !nackFlag && !stopDet, "R10 flags cleared",
        int'(txEnd) + int'(nackFlag) + int'(stopDet), 0);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    chk(bufEmpty == 1 && !txEnd && !nackFlag && !ackBit && !busBusy && !stopDet,
        "R1 flags at reset", {bufEmpty, txEnd, nackFlag, ackBit, busBusy, stopDet}, 6'b100000);
    chk(!sclOe && !sdaOe, "R1 lines released", int'(sclOe) + int'(sdaOe), 0);

    // R8/R9: start then stop with no data, stop taken from the parked state
    quarterDiv = 8'd1; curQ = 1;
    pulseStart();
    idle(40);
    chk(sclOe == 1'b1 && rxCount == 0, "R8 parked, no data", rxCount, 0);
    pulseStop();
    waitIdle();
    chk(stopDet && rxCount == 0 && stopCnt == 1, "R9 empty transfer stop", stopCnt, 1);

    // R10: selective clear
    clear(3'b011);
    chk(stopDet == 1'b1, "R10 stopDet kept", stopDet, 1);
    clear(3'b100);
    chk(stopDet == 1'b0, "R10 stopDet cleared", stopDet, 0);

    // R2: start ignored while busy; R7: refused byte with detection off
    runTxn(3, 99, 1'b1, 0, 1, 1'b1);
    runTxn(3, 1, 1'b0, 0, 0, 1'b0);
    runTxn(2, 0, 1'b1, 30, 2, 1'b0);

    // R11: stop beats a waiting byte
    begin
      int p0;
      p0 = stopCnt; nackIdx = 99; quarterDiv = 8'd1; curQ = 1;
      pulseStart();
      writeByte(8'hA6);
      waitEmpty();
      writeByte(8'h5B);
      pulseStop();
      waitIdle();
      chk(rxCount == 1 && rxBuf[0] == 8'hA6, "R11 only first byte sent", rxCount, 1);
      chk(bufEmpty == 1'b1, "R11 waiting byte dropped", bufEmpty, 1);
      chk(stopCnt == p0 + 1, "R11 stop issued", stopCnt - p0, 1);
      chk(txEnd == 1'b0, "R5 no txEnd with data waiting", txEnd, 0);
      clear(3'b111);
    end

    // constrained random transfers
    for (int k = 0; k < 24; k++) begin
      int n, nk, st;
      n  = 1 + int'($urandom % 5);
      nk = int'($urandom % 8);
      st = ($urandom % 3 == 0) ? 20 + int'($urandom % 40) : 0;
      runTxn(n, nk, 1'($urandom), st, int'($urandom % 4), 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule